// File: doc/BRIEF.md
# Codec Register Access Controller

This block carries software reads and writes of codec control registers across a frame-based serial audio link. Software writes one 32-bit command word: the top bit selects read (1) or write (0), bits 22:16 name one of 128 codec registers, bits 15:0 hold the write value, and bits 30:23 are reserved and expected to be zero. The controller holds the command and offers it to the serializer as the contents of the two outgoing command slots. It raises the slot tag bits for exactly one frame.

A write is finished once the frame that carried it has ended. A read then waits for an incoming frame from a ready codec whose status-address slot returns the same register index and whose tag marks both status slots valid. The 16-bit value in bits 19:4 of the status-data slot is kept and shown on the read-data port. Completion of either kind is signalled by a one-cycle done pulse that feeds the interrupt logic. A busy flag stays high from acceptance until that pulse.

Frame boundaries arrive as a one-cycle `frame_sync_i` pulse. At that pulse the serializer latches the outgoing slot contents for the frame that begins, and the frame before it ends. Incoming frames are presented as one-cycle `rx_frame_i` strobes together with the received tag word and slots 1 and 2.

Top module: `cra_ctrl`

## Requirements
- R1: After reset, busy, done and both outgoing tag bits are low, both outgoing slots are zero and the read-data port reads zero.
- R2: A command write while idle is accepted. From the next cycle busy is high and outgoing slot 1 holds the direction in bit 19, the register index in bits 18:12 and zeros in bits 11:0.
- R3: For a write command, outgoing slot 2 holds the write data in bits 19:4 with zeros in bits 3:0, and both outgoing tag bits (slot 1, slot 2) are high.
- R4: For a read command, only the slot 1 tag bit is high and the slot 2 tag bit stays low.
- R5: The outgoing tag bits and slot contents are presented only until the first frame_sync_i after acceptance. From the cycle after that pulse, both tags are low and both slots read zero.
- R6: A write completes at the second frame_sync_i after acceptance, which is the end of the frame that carried it. In the cycle after that pulse done is high and busy is low.
- R7: A read completes on the first incoming frame, after its command frame has ended, with tag bits 15 (codec ready), 14 (slot 1 valid) and 13 (slot 2 valid) all set and received slot 1 bits 18:12 equal to the requested index. In the next cycle done is high, busy is low and bits 15:0 of the read-data port hold received slot 2 bits 19:4, with bits 31:16 zero.
- R8: An incoming frame with the codec not ready, either status tag bit clear, or a different index leaves a pending read pending: busy stays high, done stays low and the read data is unchanged.
- R9: A command written while busy is ignored. The outgoing slots keep the first command and the completion follows the first command.
- R10: Done is a single-cycle pulse, one per accepted command, and never occurs while idle without a command.
- R11: Incoming frames while idle or during a write do not change the read-data port. A write completion leaves it holding the last read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 32 | Command word |
| rd_data_o | output | 32 | Command register read value, captured data in bits 15:0 |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse to the interrupt logic |
| frame_sync_i | input | 1 | Frame boundary pulse from the serializer |
| tx_slot1_vld_o | output | 1 | Outgoing tag bit for slot 1 |
| tx_slot2_vld_o | output | 1 | Outgoing tag bit for slot 2 |
| tx_slot1_o | output | 20 | Outgoing command-address slot |
| tx_slot2_o | output | 20 | Outgoing command-data slot |
| rx_frame_i | input | 1 | Strobe: an incoming frame's tag and slots are valid |
| rx_tag_i | input | 16 | Incoming tag word |
| rx_slot1_i | input | 20 | Incoming status-address slot |
| rx_slot2_i | input | 20 | Incoming status-data slot |

## Verification
The bench sends a second command while the first is in flight. A controller that reloads its holding register would change slot 1 mid-frame and complete the wrong access. During a pending read it feeds frames from a codec that is not ready, frames with one status tag bit missing, and frames with a wrong index. A loose matcher would finish early with stale or wrong data. It also feeds a matching status frame during a write and while idle, which a capture path not gated by the read state would let corrupt the read-data port. Edge values (index 0x7F, data 0xFFFF, nonzero low nibble in the status slot) catch off-by-one field slicing.

// File: rtl/cra_pkg.sv
package cra_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,  // slots offered, waiting for the frame to start
    ST_XMIT = 2'd2,  // command frame on the wire
    ST_WAIT = 2'd3   // read: waiting for status slots
  } cra_state_e;
endpackage

// File: rtl/cra_cmd_latch.sv
module cra_cmd_latch #(
  parameter int CMD_W  = 32,
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic              rd_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int RSV_LO = DATA_W + IDX_W;
  localparam int RSV_HI = CMD_W - 2;

  logic unused_rsvd;
  assign unused_rsvd = ^cmd_i[RSV_HI:RSV_LO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_o   <= 1'b0;
      idx_o  <= '0;
      data_o <= '0;
    end else if (load_i) begin
      rd_o   <= cmd_i[CMD_W-1];
      idx_o  <= cmd_i[DATA_W +: IDX_W];
      data_o <= cmd_i[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/cra_seq.sv
module cra_seq
  import cra_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_wr_i,
  input  logic       frame_sync_i,
  input  logic       rd_i,
  input  logic       hit_i,
  output logic       accept_o,
  output logic       capture_o,
  output cra_state_e state_o,
  output logic       done_o
);
  cra_state_e state_q, state_d;
  logic       fin;

  assign accept_o  = cmd_wr_i && (state_q == ST_IDLE);
  assign capture_o = (state_q == ST_WAIT) && hit_i;

  always_comb begin
    state_d = state_q;
    fin     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cmd_wr_i) state_d = ST_SEND;
      ST_SEND: if (frame_sync_i) state_d = ST_XMIT;
      ST_XMIT: if (frame_sync_i) begin
        if (rd_i) state_d = ST_WAIT;
        else begin
          state_d = ST_IDLE;
          fin     = 1'b1;
        end
      end
      ST_WAIT: if (hit_i) begin
        state_d = ST_IDLE;
        fin     = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= fin;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/cra_rx_match.sv
module cra_rx_match #(
  parameter int SLOT_W    = 20,
  parameter int TAG_W     = 16,
  parameter int IDX_W     = 7,
  parameter int DATA_W    = 16,
  parameter int READY_BIT = 15,
  parameter int S1_BIT    = 14,
  parameter int S2_BIT    = 13
) (
  input  logic              rx_frame_i,
  input  logic [TAG_W-1:0]  rx_tag_i,
  input  logic [SLOT_W-1:0] rx_slot1_i,
  input  logic [SLOT_W-1:0] rx_slot2_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int IDX_HI = SLOT_W - 2;
  localparam int PAD1   = SLOT_W - 1 - IDX_W;
  localparam int PAD2   = SLOT_W - DATA_W;

  logic tags_ok;
  logic unused_rx;
  assign unused_rx = ^{rx_slot1_i[SLOT_W-1], rx_slot1_i[PAD1-1:0],
                       rx_slot2_i[PAD2-1:0], rx_tag_i};

  assign tags_ok = rx_tag_i[READY_BIT] && rx_tag_i[S1_BIT] && rx_tag_i[S2_BIT];
  assign hit_o   = rx_frame_i && tags_ok && (rx_slot1_i[IDX_HI -: IDX_W] == idx_i);
  assign data_o  = rx_slot2_i[SLOT_W-1 -: DATA_W];
endmodule

// File: rtl/cra_ctrl.sv
module cra_ctrl
  import cra_pkg::*;
#(
  parameter int CMD_W  = 32,
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16,
  parameter int SLOT_W = 20,
  parameter int TAG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  output logic [CMD_W-1:0]  rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  input  logic              frame_sync_i,
  output logic              tx_slot1_vld_o,
  output logic              tx_slot2_vld_o,
  output logic [SLOT_W-1:0] tx_slot1_o,
  output logic [SLOT_W-1:0] tx_slot2_o,
  input  logic              rx_frame_i,
  input  logic [TAG_W-1:0]  rx_tag_i,
  input  logic [SLOT_W-1:0] rx_slot1_i,
  input  logic [SLOT_W-1:0] rx_slot2_i
);
  localparam int PAD1 = SLOT_W - 1 - IDX_W;
  localparam int PAD2 = SLOT_W - DATA_W;

  logic              accept, capture, hit, cmd_rd, sending;
  logic [IDX_W-1:0]  cmd_idx;
  logic [DATA_W-1:0] cmd_data, rx_data, cap_q;
  cra_state_e        state;

  cra_cmd_latch #(.CMD_W(CMD_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_cmd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .cmd_i (cmd_wdata_i),
    .rd_o  (cmd_rd),
    .idx_o (cmd_idx),
    .data_o(cmd_data)
  );

  cra_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_wr_i    (cmd_wr_i),
    .frame_sync_i(frame_sync_i),
    .rd_i        (cmd_rd),
    .hit_i       (hit),
    .accept_o    (accept),
    .capture_o   (capture),
    .state_o     (state),
    .done_o      (done_o)
  );

  cra_rx_match #(.SLOT_W(SLOT_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rx (
    .rx_frame_i(rx_frame_i),
    .rx_tag_i  (rx_tag_i),
    .rx_slot1_i(rx_slot1_i),
    .rx_slot2_i(rx_slot2_i),
    .idx_i     (cmd_idx),
    .hit_o     (hit),
    .data_o    (rx_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cap_q <= '0;
    else if (capture) cap_q <= rx_data;
  end

  assign sending        = (state == ST_SEND);
  assign busy_o         = (state != ST_IDLE);
  assign tx_slot1_vld_o = sending;
  assign tx_slot2_vld_o = sending && !cmd_rd;
  assign tx_slot1_o     = sending ? {cmd_rd, cmd_idx, {PAD1{1'b0}}} : '0;
  assign tx_slot2_o     = sending ? {cmd_data, {PAD2{1'b0}}} : '0;
  assign rd_data_o      = {{(CMD_W-DATA_W){1'b0}}, cap_q};
endmodule

// File: rtl/cra_ctrl_chk.sv
module cra_ctrl_chk #(
  parameter int CMD_W  = 32,
  parameter int SLOT_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_wr_i,
  input logic [CMD_W-1:0]  rd_data_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              frame_sync_i,
  input logic              tx_slot1_vld_o,
  input logic              tx_slot2_vld_o,
  input logic [SLOT_W-1:0] tx_slot1_o
);
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !busy_o) |=> busy_o);

  p_slot2_needs_slot1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_slot2_vld_o |-> tx_slot1_vld_o);

  p_read_no_slot2_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_slot1_vld_o && tx_slot1_o[SLOT_W-1]) |-> !tx_slot2_vld_o);

  p_tags_one_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_slot1_vld_o && frame_sync_i) |=> (!tx_slot1_vld_o && !tx_slot2_vld_o));

  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_rdata_only_on_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o != $past(rd_data_o)) |-> done_o);

  p_slot_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_slot1_vld_o && $past(tx_slot1_vld_o)) |-> $stable(tx_slot1_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind cra_ctrl cra_ctrl_chk #(.CMD_W(CMD_W), .SLOT_W(SLOT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_wr_i      (cmd_wr_i),
  .rd_data_o     (rd_data_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .frame_sync_i  (frame_sync_i),
  .tx_slot1_vld_o(tx_slot1_vld_o),
  .tx_slot2_vld_o(tx_slot2_vld_o),
  .tx_slot1_o    (tx_slot1_o)
);

// File: tb/cra_ctrl_test.sv
`timescale 1ns/1ps
module cra_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] rd_data;
  logic        busy, done;
  logic        frame_sync = 1'b0;
  logic        t1v, t2v;
  logic [19:0] t1, t2;
  logic        rx_frame = 1'b0;
  logic [15:0] rx_tag = '0;
  logic [19:0] rx_s1 = '0, rx_s2 = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];

  always #5 clk = ~clk;

  cra_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata),
    .rd_data_o(rd_data), .busy_o(busy), .done_o(done), .frame_sync_i(frame_sync),
    .tx_slot1_vld_o(t1v), .tx_slot2_vld_o(t2v), .tx_slot1_o(t1), .tx_slot2_o(t2),
    .rx_frame_i(rx_frame), .rx_tag_i(rx_tag), .rx_slot1_i(rx_s1), .rx_slot2_i(rx_s2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: issue a command; expected read-data value at its completion goes to the scoreboard
  task automatic issue(input bit rd, input logic [6:0] idx, input logic [15:0] d,
                       input logic [31:0] exp_rd, input bit push);
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_wdata = {rd, 8'h00, idx, d};
    if (push) exp_q.push_back(exp_rd);
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic sync_pulse();
    @(negedge clk);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  task automatic rx(input logic [15:0] tag, input logic [19:0] s1, input logic [19:0] s2);
    @(negedge clk);
    rx_frame = 1'b1; rx_tag = tag; rx_s1 = s1; rx_s2 = s2;
    @(negedge clk);
    rx_frame = 1'b0; rx_tag = '0;
  endtask

  // monitor: pop expected read data at each completion (R10: one pulse per command)
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 actual unexpected done expected none");
      end else begin
        chk("R7 R11 done read data", rd_data, exp_q.pop_front());
        chk("R6 R7 busy at done", {31'b0, busy}, 32'd0);
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 done", {31'b0, done}, 0);
    chk("R1 tags", {30'b0, t1v, t2v}, 0);
    chk("R1 slots", {t1, 12'b0}, 0);
    chk("R1 slot2", {12'b0, t2}, 0);
    chk("R1 rdata", rd_data, 0);
    rst_n = 1'b1;

    // idle incoming frame must not touch read data (R11)
    rx(16'hE000, 20'h2A000, 20'hAAAA0);
    chk("R11 idle rx", rd_data, 0);

    // write idx 0x2A data 0xBEEF
    issue(1'b0, 7'h2A, 16'hBEEF, 32'h0, 1'b1);
    chk("R2 busy", {31'b0, busy}, 1);
    chk("R2 slot1", {12'b0, t1}, 32'h2A000);
    chk("R3 slot2", {12'b0, t2}, 32'hBEEF0);
    chk("R3 tags", {30'b0, t1v, t2v}, 32'd3);
    // R9 command while busy is ignored
    issue(1'b1, 7'h05, 16'h0000, 32'h0, 1'b0);
    chk("R9 slot1 held", {12'b0, t1}, 32'h2A000);
    chk("R9 slot2 held", {12'b0, t2}, 32'hBEEF0);
    sync_pulse();
    chk("R5 tags drop", {30'b0, t1v, t2v}, 0);
    chk("R5 slot1 clear", {12'b0, t1}, 0);
    chk("R5 busy", {31'b0, busy}, 1);
    rx(16'hE000, 20'h2A000, 20'h55550);
    chk("R11 rx during write", rd_data, 0);
    chk("R6 no early done", {31'b0, busy}, 1);
    sync_pulse(); // done here, monitor checks

    // read idx 0x05
    issue(1'b1, 7'h05, 16'h9999, 32'h1234, 1'b1);
    chk("R4 slot1", {12'b0, t1}, 32'h85000);
    chk("R4 tags", {30'b0, t1v, t2v}, 32'd2);
    sync_pulse();
    sync_pulse();
    chk("R7 waiting", {31'b0, busy}, 1);
    rx(16'h6000, 20'h05000, 20'h11110);     // codec not ready
    chk("R8 not ready busy", {31'b0, busy}, 1);
    rx(16'hC000, 20'h05000, 20'h22220);     // slot 2 tag clear
    chk("R8 no slot2 tag busy", {31'b0, busy}, 1);
    rx(16'hA000, 20'h05000, 20'h22220);     // slot 1 tag clear
    chk("R8 no slot1 tag busy", {31'b0, busy}, 1);
    rx(16'hE000, 20'h06000, 20'h33330);     // wrong index
    chk("R8 wrong idx busy", {31'b0, busy}, 1);
    chk("R8 rdata kept", rd_data, 0);
    rx(16'hE000, 20'h85000, 20'h1234A);     // match, low nibble ignored

    // boundary read: idx 0x7F, data 0xFFFF
    issue(1'b1, 7'h7F, 16'h0000, 32'hFFFF, 1'b1);
    chk("R4 slot1 max idx", {12'b0, t1}, 32'hFF000);
    sync_pulse();
    sync_pulse();
    rx(16'hE000, 20'h7F000, 20'hFFFF5);

    // write after read keeps last read value (R11)
    issue(1'b0, 7'h00, 16'h0001, 32'hFFFF, 1'b1);
    chk("R3 slot2 small", {12'b0, t2}, 32'h00010);
    sync_pulse();
    sync_pulse();
    repeat (3) @(negedge clk);
    chk("R10 all completions seen", exp_q.size(), 0);
    chk("R10 no stray done", {31'b0, done}, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule